// File: doc/BRIEF.md
# Packet Header Exception Classifier

This block receives the decoded IP and TCP/UDP header fields of one packet, together with pass/fail results from checksum engines that sit elsewhere. It gives back a single verdict: an exception class and a small numeric code that a downstream stage writes into the packet's work-queue descriptor. Extracting the fields from the byte stream and computing checksums both happen upstream.

Every condition is evaluated in parallel into a vector of hit flags. A first-hit picker then chooses the reported condition. IP-level exceptions always win over transport-level errors. Among the transport-level errors, a header that is too short comes first, then a length disagreement, then a checksum failure, then a zero port, and finally the suspicious TCP flag patterns.

The class output is needed because IP exception codes and transport error codes share the same numeric values. The verdict is registered and offered on a valid/ready interface. A new header is taken only when the output register is empty or is being drained in the same cycle.

Top module: `hdr_exc_classifier`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: When `ip_ver` is neither 4 nor 6, the verdict is class 1 (IP) with code 1.
- R3: When the version is 4 and `ip_csum_ok` is low, the code is 2 (class IP). For version 6, `ip_csum_ok` has no effect.
- R4: When `pkt_len < ip_hdr_len`, the code is 3. Otherwise, when `pkt_len < ip_tot_len`, the code is 4 (class IP).
- R5: When `ip_ttl` is zero, the code is 5. When `ip_opts` is high, the code is 6 (class IP).
- R6: When several IP conditions hold, the lowest IP code is reported. Any IP exception suppresses every transport error.
- R7: `l4_kind` encodes the transport: 1 is TCP, 2 is UDP, and 0 or 3 is other. For TCP or UDP, when `pkt_len < ip_hdr_len + H`, the verdict is class 2 (L4) with code 1. H is 20 bytes for TCP and 8 for UDP.
- R8: When `l4_len` differs from `ip_tot_len - ip_hdr_len` (a negative difference always differs), the code is 3. Otherwise, when `l4_csum_ok` is low, the code is 2. The short-header code takes precedence over both.
- R9: When `src_port` or `dst_port` is zero and no earlier L4 code applies, the code is 4.
- R10: For TCP, with flag bits FIN=bit0, SYN=bit1, RST=bit2, PSH=bit3, ACK=bit4 and URG=bit5, the first matching rule in this list is reported:
  - flags exactly FIN gives code 8;
  - no flags gives code 9;
  - FIN and RST together give code 10;
  - SYN and URG together give code 11;
  - SYN and RST together give code 12;
  - SYN and FIN together give code 13.
- R11: For UDP, the flag bits have no effect. For the other `l4_kind` values, no L4 check applies.
- R12: When no condition holds, the verdict is class 0 with code 0.
- R13: The verdict appears on the outputs in the cycle after acceptance (`in_valid && in_ready`). It is held stable while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header fields are present |
| in_ready | output | 1 | Header fields will be taken this cycle |
| pkt_len | input | 16 | Received packet length in bytes, starting at the IP header |
| ip_ver | input | 4 | IP version field |
| ip_hdr_len | input | 16 | IP header length in bytes |
| ip_tot_len | input | 16 | Total length in bytes claimed by the IP header |
| ip_ttl | input | 8 | TTL or hop limit |
| ip_csum_ok | input | 1 | IPv4 header checksum passed |
| ip_opts | input | 1 | IPv4 options or IPv6 early extension header present |
| l4_kind | input | 2 | Transport: 1 TCP, 2 UDP, else other |
| l4_len | input | 16 | Transport length in bytes |
| l4_csum_ok | input | 1 | TCP/UDP checksum passed |
| src_port | input | 16 | Source port |
| dst_port | input | 16 | Destination port |
| tcp_flags | input | 6 | TCP flags, FIN at bit 0 through URG at bit 5 |
| out_valid | output | 1 | Verdict is present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_class | output | 2 | 0 none, 1 IP exception, 2 L4 error |
| out_code | output | 4 | Exception or error code |

## Verification
A wrong priority in the hit vectors or in the picker shows up as a wrong class or code in the first cycle after the header is accepted. The bench's fault-mask sweep is built to catch this, because it turns on many conditions at once. A faulty output register or ready path shows up as a verdict that changes during a stall, or as a header that is lost or taken twice. Either is visible within one or two cycles of a held `out_ready`.

// File: rtl/hdr_exc_pkg.sv
package hdr_exc_pkg;
  localparam int IP_N = 6;
  localparam int L4_N = 10;
  localparam logic [1:0] KIND_TCP = 2'd1;
  localparam logic [1:0] KIND_UDP = 2'd2;
  localparam logic [1:0] CLS_NONE = 2'd0;
  localparam logic [1:0] CLS_IP   = 2'd1;
  localparam logic [1:0] CLS_L4   = 2'd2;
  localparam int F_FIN = 0;
  localparam int F_SYN = 1;
  localparam int F_RST = 2;
  localparam int F_URG = 5;

  // IP hit index i maps to code i+1
  function automatic logic [3:0] ip_code_of(input logic [2:0] idx);
    return {1'b0, idx} + 4'd1;
  endfunction

  // L4 hit order: short hdr, length, checksum, port, flags 8..13
  function automatic logic [3:0] l4_code_of(input logic [3:0] idx);
    case (idx)
      4'd0: return 4'd1;
      4'd1: return 4'd3;
      4'd2: return 4'd2;
      4'd3: return 4'd4;
      default: return idx + 4'd4;
    endcase
  endfunction

  // bit k of result corresponds to flag code 8+k
  function automatic logic [5:0] tcp_flag_hits(input logic [5:0] f);
    logic [5:0] h;
    h[0] = (f == 6'b000001);
    h[1] = (f == 6'b000000);
    h[2] = f[F_FIN] & f[F_RST];
    h[3] = f[F_SYN] & f[F_URG];
    h[4] = f[F_SYN] & f[F_RST];
    h[5] = f[F_SYN] & f[F_FIN];
    return h;
  endfunction
endpackage

// File: rtl/hdr_exc_ip_check.sv
module hdr_exc_ip_check
  import hdr_exc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [3:0]       ip_ver,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [LEN_W-1:0] ip_hdr_len,
  input  logic [LEN_W-1:0] ip_tot_len,
  input  logic [7:0]       ip_ttl,
  input  logic             ip_csum_ok,
  input  logic             ip_opts,
  output logic [IP_N-1:0]  hits
);
  logic is_v4, is_v6;
  assign is_v4 = (ip_ver == 4'd4);
  assign is_v6 = (ip_ver == 4'd6);

  assign hits[0] = !(is_v4 || is_v6);
  assign hits[1] = is_v4 && !ip_csum_ok;
  assign hits[2] = pkt_len < ip_hdr_len;
  assign hits[3] = pkt_len < ip_tot_len;
  assign hits[4] = (ip_ttl == 8'd0);
  assign hits[5] = ip_opts;
endmodule

// File: rtl/hdr_exc_l4_check.sv
module hdr_exc_l4_check
  import hdr_exc_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int TCP_HDR_BYTES = 20,
  parameter int UDP_HDR_BYTES = 8
) (
  input  logic [1:0]       l4_kind,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [LEN_W-1:0] ip_hdr_len,
  input  logic [LEN_W-1:0] ip_tot_len,
  input  logic [LEN_W-1:0] l4_len,
  input  logic             l4_csum_ok,
  input  logic [15:0]      src_port,
  input  logic [15:0]      dst_port,
  input  logic [5:0]       tcp_flags,
  output logic [L4_N-1:0]  hits
);
  localparam int XW = LEN_W + 1;

  logic          is_tcp, is_udp, is_l4;
  logic [XW-1:0] hdr_need, l4_expect;
  logic [3:0]    base_hits;
  logic [5:0]    flag_hits;

  assign is_tcp = (l4_kind == KIND_TCP);
  assign is_udp = (l4_kind == KIND_UDP);
  assign is_l4  = is_tcp || is_udp;

  // widened so that a large header length cannot wrap
  assign hdr_need  = {1'b0, ip_hdr_len} +
                     (is_tcp ? XW'(TCP_HDR_BYTES) : XW'(UDP_HDR_BYTES));
  // a negative difference sets the top bit and never matches
  assign l4_expect = {1'b0, ip_tot_len} - {1'b0, ip_hdr_len};

  assign base_hits[0] = {1'b0, pkt_len} < hdr_need;
  assign base_hits[1] = l4_expect != {1'b0, l4_len};
  assign base_hits[2] = !l4_csum_ok;
  assign base_hits[3] = (src_port == 16'd0) || (dst_port == 16'd0);

  assign flag_hits = tcp_flag_hits(tcp_flags);

  assign hits = {flag_hits & {6{is_tcp}}, base_hits & {4{is_l4}}};
endmodule

// File: rtl/hdr_exc_first_hit.sv
module hdr_exc_first_hit #(
  parameter int N     = 6,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | req[i];
    assign grant[i]  = req[i] & ~seen[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

  assign found = seen[N];
endmodule

// File: rtl/hdr_exc_out_reg.sv
module hdr_exc_out_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] nxt_class,
  input  logic [3:0] nxt_code,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [1:0] out_class,
  output logic [3:0] out_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_class <= 2'd0;
      out_code  <= 4'd0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_class <= nxt_class;
      out_code  <= nxt_code;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_exc_classifier.sv
module hdr_exc_classifier
  import hdr_exc_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int TCP_HDR_BYTES = 20,
  parameter int UDP_HDR_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [3:0]       ip_ver,
  input  logic [LEN_W-1:0] ip_hdr_len,
  input  logic [LEN_W-1:0] ip_tot_len,
  input  logic [7:0]       ip_ttl,
  input  logic             ip_csum_ok,
  input  logic             ip_opts,
  input  logic [1:0]       l4_kind,
  input  logic [LEN_W-1:0] l4_len,
  input  logic             l4_csum_ok,
  input  logic [15:0]      src_port,
  input  logic [15:0]      dst_port,
  input  logic [5:0]       tcp_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_class,
  output logic [3:0]       out_code
);
  localparam int IP_IW = $clog2(IP_N);
  localparam int L4_IW = $clog2(L4_N);

  logic [IP_N-1:0]  ip_hits;
  logic [L4_N-1:0]  l4_hits;
  logic             ip_any, l4_any, accept;
  logic [IP_IW-1:0] ip_idx;
  logic [L4_IW-1:0] l4_idx;
  logic [1:0]       nxt_class;
  logic [3:0]       nxt_code;

  hdr_exc_ip_check #(.LEN_W(LEN_W)) ip_chk_i (
    .ip_ver(ip_ver), .pkt_len(pkt_len), .ip_hdr_len(ip_hdr_len),
    .ip_tot_len(ip_tot_len), .ip_ttl(ip_ttl), .ip_csum_ok(ip_csum_ok),
    .ip_opts(ip_opts), .hits(ip_hits)
  );

  hdr_exc_l4_check #(
    .LEN_W(LEN_W), .TCP_HDR_BYTES(TCP_HDR_BYTES), .UDP_HDR_BYTES(UDP_HDR_BYTES)
  ) l4_chk_i (
    .l4_kind(l4_kind), .pkt_len(pkt_len), .ip_hdr_len(ip_hdr_len),
    .ip_tot_len(ip_tot_len), .l4_len(l4_len), .l4_csum_ok(l4_csum_ok),
    .src_port(src_port), .dst_port(dst_port), .tcp_flags(tcp_flags),
    .hits(l4_hits)
  );

  hdr_exc_first_hit #(.N(IP_N), .IDX_W(IP_IW)) ip_pick_i (
    .req(ip_hits), .found(ip_any), .idx(ip_idx)
  );

  hdr_exc_first_hit #(.N(L4_N), .IDX_W(L4_IW)) l4_pick_i (
    .req(l4_hits), .found(l4_any), .idx(l4_idx)
  );

  always_comb begin
    if (ip_any) begin
      nxt_class = CLS_IP;
      nxt_code  = ip_code_of(ip_idx);
    end else if (l4_any) begin
      nxt_class = CLS_L4;
      nxt_code  = l4_code_of(l4_idx);
    end else begin
      nxt_class = CLS_NONE;
      nxt_code  = 4'd0;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  hdr_exc_out_reg out_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .nxt_class(nxt_class),
    .nxt_code(nxt_code), .out_ready(out_ready), .out_valid(out_valid),
    .out_class(out_class), .out_code(out_code)
  );
endmodule

// File: rtl/hdr_exc_chk.sv
module hdr_exc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       ip_any,
  input logic       l4_any,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_class,
  input logic [3:0] out_code
);
  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_class) && $stable(out_code)));

  // R13
  load_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R6
  ip_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ip_any) |=> (out_class == 2'd1));

  // R12
  clean_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ip_any && !l4_any) |=> (out_class == 2'd0 && out_code == 4'd0));

  // R5
  ip_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'd1) |-> (out_code >= 4'd1 && out_code <= 4'd6));

  // R10
  l4_code_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 2'd2) |->
      ((out_code >= 4'd1 && out_code <= 4'd4) || (out_code >= 4'd8 && out_code <= 4'd13)));
endmodule

bind hdr_exc_classifier hdr_exc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept), .ip_any(ip_any), .l4_any(l4_any),
  .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
  .out_code(out_code)
);

// File: tb/hdr_exc_classifier_tb_top.sv
module hdr_exc_classifier_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] pkt_len = '0, ip_hdr_len = '0, ip_tot_len = '0, l4_len = '0;
  logic [3:0]  ip_ver = '0;
  logic [7:0]  ip_ttl = '0;
  logic        ip_csum_ok = 1'b1, ip_opts = 1'b0, l4_csum_ok = 1'b1;
  logic [1:0]  l4_kind = '0;
  logic [15:0] src_port = '0, dst_port = '0;
  logic [5:0]  tcp_flags = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [1:0]  out_class;
  logic [3:0]  out_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int txn_n  = 0;

  always #4 clk = ~clk;

  hdr_exc_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pkt_len(pkt_len), .ip_ver(ip_ver), .ip_hdr_len(ip_hdr_len),
    .ip_tot_len(ip_tot_len), .ip_ttl(ip_ttl), .ip_csum_ok(ip_csum_ok),
    .ip_opts(ip_opts), .l4_kind(l4_kind), .l4_len(l4_len),
    .l4_csum_ok(l4_csum_ok), .src_port(src_port), .dst_port(dst_port),
    .tcp_flags(tcp_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_code(out_code)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference verdict, returned as class*16 + code
  function automatic int ref_eval();
    int p, h, t, need, c;
    bit tcp, udp, fin, syn, rst, urg;
    p = pkt_len; h = ip_hdr_len; t = ip_tot_len;
    if (ip_ver != 4 && ip_ver != 6) return 16 + 1;
    if (ip_ver == 4 && !ip_csum_ok) return 16 + 2;
    if (p < h) return 16 + 3;
    if (p < t) return 16 + 4;
    if (ip_ttl == 0) return 16 + 5;
    if (ip_opts) return 16 + 6;
    tcp = (l4_kind == 2'd1);
    udp = (l4_kind == 2'd2);
    if (!tcp && !udp) return 0;
    need = h + (tcp ? 20 : 8);
    if (p < need) return 32 + 1;
    if (int'(l4_len) != t - h) return 32 + 3;
    if (!l4_csum_ok) return 32 + 2;
    if (src_port == 0 || dst_port == 0) return 32 + 4;
    if (!tcp) return 0;
    fin = tcp_flags[0]; syn = tcp_flags[1]; rst = tcp_flags[2]; urg = tcp_flags[5];
    c = 0;
    if (tcp_flags == 6'b000001) c = 8;
    else if (tcp_flags == 6'b000000) c = 9;
    else if (fin && rst) c = 10;
    else if (syn && urg) c = 11;
    else if (syn && rst) c = 12;
    else if (syn && fin) c = 13;
    return (c != 0) ? 32 + c : 0;
  endfunction

  function automatic string req_of(int v);
    int cl, cd;
    cl = v / 16; cd = v % 16;
    if (cl == 0) return "R12";
    if (cl == 1) begin
      if (cd == 1) return "R2";
      if (cd == 2) return "R3";
      if (cd <= 4) return "R4";
      return "R5";
    end
    if (cd == 1) return "R7";
    if (cd <= 3) return "R8";
    if (cd == 4) return "R9";
    return "R10";
  endfunction

  task automatic check_bit(input string rq, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", rq, act, exp_v);
    end
  endtask

  task automatic check_out(input string rq, input int exp_v);
    checks++;
    if (out_valid !== 1'b1 || int'(out_class) != exp_v / 16 || int'(out_code) != exp_v % 16) begin
      errors++;
      $display("FAIL %s: actual valid %0b class %0d code %0d expected class %0d code %0d",
               rq, out_valid, out_class, out_code, exp_v / 16, exp_v % 16);
    end
  endtask

  // called right after a falling edge with the fields already set
  task automatic txn(input string lbl);
    int e;
    string rq;
    e  = ref_eval();
    rq = (lbl == "") ? req_of(e) : lbl;
    txn_n++;
    in_valid  = 1'b1;
    out_ready = 1'b0;
    check_bit("R13", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(rq, e);
    if (txn_n % 7 == 0) begin
      @(negedge clk);
      check_out("R13", e);
      check_bit("R13", in_ready, 1'b0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check_bit("R13", out_valid, 1'b0);
    out_ready = 1'b0;
  endtask

  task automatic set_base();
    ip_ver = 4'd4; ip_hdr_len = 16'd20; ip_tot_len = 16'd100; pkt_len = 16'd100;
    ip_ttl = 8'd64; ip_csum_ok = 1'b1; ip_opts = 1'b0; l4_kind = 2'd1;
    l4_len = 16'd80; l4_csum_ok = 1'b1; src_port = 16'd1000; dst_port = 16'd80;
    tcp_flags = 6'b010000;
  endtask

  initial begin
    int e;
    set_base();
    repeat (3) @(negedge clk);
    // R1
    check_bit("R1", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1", out_valid, 1'b0);
    check_bit("R1", in_ready, 1'b1);

    // clean packets: R12
    set_base(); txn("R12");
    l4_kind = 2'd2; txn("R12");

    // R3: IPv6 ignores the header checksum input
    set_base(); ip_ver = 4'd6; ip_csum_ok = 1'b0; txn("R3");

    // R6: several IP faults plus an L4 fault
    set_base(); ip_ver = 4'd9; ip_ttl = 8'd0; src_port = 16'd0; txn("R6");
    set_base(); ip_opts = 1'b1; ip_ttl = 8'd0; tcp_flags = 6'd0; txn("R6");

    // R10: all TCP flag patterns on a clean packet
    for (int f = 0; f < 64; f++) begin
      set_base(); tcp_flags = 6'(f); txn("");
    end
    // R11: UDP and other transports ignore flags / L4 checks
    for (int f = 0; f < 64; f++) begin
      set_base(); l4_kind = 2'd2; tcp_flags = 6'(f); txn("R11");
    end
    for (int k = 0; k < 4; k += 3) begin
      set_base(); l4_kind = 2'(k); l4_csum_ok = 1'b0; src_port = 16'd0;
      tcp_flags = 6'd0; txn("R11");
    end

    // fault-mask sweep over all kinds
    for (int k = 0; k < 3; k++) begin
      for (int m = 0; m < 1024; m++) begin
        set_base();
        l4_kind = (k == 0) ? 2'd1 : (k == 1) ? 2'd2 : 2'd0;
        if (m[6]) begin ip_tot_len = 16'd24; pkt_len = 16'd24; l4_len = 16'd4; end
        if (m[0]) ip_ver = 4'd7;
        if (m[1]) ip_csum_ok = 1'b0;
        if (m[2]) ip_hdr_len = 16'd120;
        if (m[3]) ip_tot_len = 16'd110;
        if (m[4]) ip_ttl = 8'd0;
        if (m[5]) ip_opts = 1'b1;
        if (m[7]) l4_len = l4_len + 16'd1;
        if (m[8]) l4_csum_ok = 1'b0;
        if (m[9]) src_port = 16'd0;
        if ($countones(m[5:0]) > 1) txn("R6");
        else txn("");
      end
    end

    // random fields in small ranges
    for (int i = 0; i < 1500; i++) begin
      ip_ver     = ($urandom % 4 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'd4 : 4'd6);
      ip_hdr_len = 16'(20 + 4 * ($urandom % 6));
      ip_tot_len = 16'(20 + $urandom % 80);
      pkt_len    = 16'(20 + $urandom % 90);
      ip_ttl     = 8'($urandom % 3);
      ip_csum_ok = ($urandom % 8) != 0;
      ip_opts    = ($urandom % 8) == 0;
      l4_kind    = 2'($urandom);
      l4_len     = ($urandom % 2) ? ip_tot_len - ip_hdr_len : 16'($urandom % 64);
      l4_csum_ok = ($urandom % 8) != 0;
      src_port   = 16'($urandom % 4);
      dst_port   = 16'($urandom % 4);
      tcp_flags  = 6'($urandom);
      txn("");
    end

    // R13: back-to-back acceptance while draining
    set_base();
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check_out("R13", 0);
    set_base(); ip_ttl = 8'd0;
    e = ref_eval();
    check_bit("R13", in_ready, 1'b1);
    @(negedge clk);
    check_out("R13", e);
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R13", out_valid, 1'b0);
    out_ready = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule